// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This unit sits between the register file of a processor and a 32-bit big-endian data memory port. It accepts one access at a time. Each access carries an opcode class, a byte address, up to two register values to store, a destination register number, an alternate-space flag and the supervisor bit. For a store it drives byte-lane write strobes and a lane-shifted write word. For a load it takes the returned memory word, picks out the byte, half-word or word the access names, and sign-extends or zero-extends that value before writing it back.

A double-word access runs as two word beats on the memory port. The first beat uses the 8-byte-aligned base address and the second uses base+4. The beats pair with register r and register r+1 in that order. Before any memory traffic starts, the unit checks the opcode code, the privilege and the alignment. If a check fails, it reports a single trap cause, makes no memory access and writes back no register.

The memory port uses a valid/ready handshake. A beat is held, unchanged, until the memory accepts it.

Top module: `lsu_align_unit`

## Requirements
- R1: Opcode encoding on `req_op`: 0 load unsigned byte, 1 load unsigned half, 2 load word, 3 load double, 4 load signed byte, 5 load signed half, 6 store byte, 7 store half, 8 store word, 9 store double. A byte store sets exactly one strobe bit, `mem_strb[3-off]`, where off is `addr[1:0]`. Strobe bit 3 covers data bits 31:24, which is byte offset 0, the most significant byte. The write word is the low byte of the source repeated four times.
- R2: A half-word store sets strobes 4'b1100 when `addr[1]` is 0 and 4'b0011 when `addr[1]` is 1. The write word is the low 16 bits of the source repeated twice.
- R3: A word store sets all four strobes and writes the source unchanged. `mem_addr` always has its two low bits at zero.
- R4: Signed byte and signed half loads take the big-endian lane chosen by the address offset and sign-extend it to 32 bits.
- R5: Unsigned byte and unsigned half loads take the same lane and zero-extend it. A word load returns the memory word unchanged.
- R6: A double access makes a beat at the base address and then a beat at base+4. Loads write register r and then r+1. Stores write `req_sdata0` and then `req_sdata1`.
- R7: While `mem_valid` is high and `mem_ready` is low, the address, strobes, write enable and write data stay stable. The second double-word beat is not issued before the first beat completes.
- R8: A half access with `addr[0]`=1, a word access with `addr[1:0]`≠0, or a double access with `addr[2:0]`≠0 raises trap cause 3 (misaligned). A byte access never raises this trap.
- R9: An access with `req_alt`=1 while `req_super`=0 raises trap cause 2 (privileged).
- R10: An opcode code of 10 to 15 raises trap cause 1 (illegal).
- R11: When several trap conditions hold, the reported cause is illegal first, then privileged, then misaligned.
- R12: A trapped access produces no memory beat and no register write-back.
- R13: `req_ready` is high only when no access is in flight. `trap_valid` pulses for one cycle, the cycle after a trapped request is accepted. `wb_valid` pulses for one cycle, the cycle after each load beat's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 4 | Opcode class code |
| req_alt | input | 1 | Alternate address space access |
| req_super | input | 1 | Supervisor mode bit |
| req_addr | input | 32 | Byte address |
| req_rd | input | 5 | Destination (or first) register number |
| req_sdata0 | input | 32 | Store source, register r |
| req_sdata1 | input | 32 | Store source, register r+1 (double only) |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_strb | output | 4 | Byte-lane write strobes, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-shifted write word |
| mem_rdata | input | 32 | Read word, valid with the handshake |
| wb_valid | output | 1 | Register write-back pulse |
| wb_reg | output | 5 | Register written back |
| wb_data | output | 32 | Extended load result |
| trap_valid | output | 1 | Trap report pulse |
| trap_cause | output | 2 | 1 illegal, 2 privileged, 3 misaligned |

## Verification
Byte stores and loads are tried at each of the four offsets against memory words whose bytes have their top bits set in different patterns. A lane that is mirrored or off by one therefore shows up, and so does a sign extension applied on the wrong side. Half-word accesses at both halves separate the signed and unsigned paths. Double-word loads and stores are run while the memory inserts wait states, which shows the beat order, the register pairing and that a stalled beat is held. Trap cases cover each single cause, byte accesses at odd offsets and requests with more than one fault, to confirm the priority order. A load after a trapped store shows that memory was left untouched.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [3:0] {
        OP_LDUB = 4'd0,
        OP_LDUH = 4'd1,
        OP_LDW  = 4'd2,
        OP_LDDW = 4'd3,
        OP_LDSB = 4'd4,
        OP_LDSH = 4'd5,
        OP_STB  = 4'd6,
        OP_STH  = 4'd7,
        OP_STW  = 4'd8,
        OP_STDW = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        TRAP_NONE    = 2'd0,
        TRAP_ILLEGAL = 2'd1,
        TRAP_PRIV    = 2'd2,
        TRAP_ALIGN   = 2'd3
    } trap_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2
    } fsm_e;

    typedef struct packed {
        logic  legal;
        logic  is_store;
        logic  is_signed;
        size_e size;
    } dec_t;

    // Opcode class to access attributes.
    function automatic dec_t decode_op(input logic [OP_W-1:0] op);
        dec_t d;
        d = '{legal: 1'b1, is_store: 1'b0, is_signed: 1'b0, size: SZ_WORD};
        case (op)
            OP_LDUB: d.size = SZ_BYTE;
            OP_LDUH: d.size = SZ_HALF;
            OP_LDW:  d.size = SZ_WORD;
            OP_LDDW: d.size = SZ_DBL;
            OP_LDSB: begin d.size = SZ_BYTE; d.is_signed = 1'b1; end
            OP_LDSH: begin d.size = SZ_HALF; d.is_signed = 1'b1; end
            OP_STB:  begin d.size = SZ_BYTE; d.is_store = 1'b1; end
            OP_STH:  begin d.size = SZ_HALF; d.is_store = 1'b1; end
            OP_STW:  begin d.size = SZ_WORD; d.is_store = 1'b1; end
            OP_STDW: begin d.size = SZ_DBL;  d.is_store = 1'b1; end
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int OFF_W = $clog2(NUM_LANES)
) (
    input  logic [OP_W-1:0] op,
    input  logic            alt,
    input  logic            super_mode,
    input  logic [OFF_W:0]  addr_low,
    output dec_t            dec,
    output trap_e           cause
);
    logic mis_half, mis_word, mis_dbl, misaligned;

    always_comb begin
        dec      = decode_op(op);
        mis_half = addr_low[0];
        mis_word = |addr_low[OFF_W-1:0];
        mis_dbl  = |addr_low;
        unique case (dec.size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = mis_half;
            SZ_WORD: misaligned = mis_word;
            SZ_DBL:  misaligned = mis_dbl;
            default: misaligned = 1'b0;
        endcase
        // Fixed priority: illegal, privileged, alignment.
        if (!dec.legal)
            cause = TRAP_ILLEGAL;
        else if (alt && !super_mode)
            cause = TRAP_PRIV;
        else if (misaligned)
            cause = TRAP_ALIGN;
        else
            cause = TRAP_NONE;
    end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(NUM_LANES)
) (
    input  size_e              size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  src,
    output logic [NUM_LANES-1:0] strb,
    output logic [DATA_W-1:0]  wdata
);
    logic [NUM_LANES-1:0] strb_byte, strb_half;

    // Lane j covers bits [8j+7:8j]; byte offset o lives in lane NUM_LANES-1-o.
    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        localparam int BOFF = NUM_LANES - 1 - j;
        assign strb_byte[j] = (off == OFF_W'(BOFF));
        assign strb_half[j] = (off[OFF_W-1:1] == (OFF_W-1)'(BOFF >> 1));
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                strb  = strb_byte;
                wdata = {NUM_LANES{src[7:0]}};
            end
            SZ_HALF: begin
                strb  = strb_half;
                wdata = {(NUM_LANES/2){src[15:0]}};
            end
            default: begin
                strb  = '1;
                wdata = src;
            end
        endcase
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int NUM_HALVES = NUM_LANES / 2,
    localparam int OFF_W = $clog2(NUM_LANES)
) (
    input  size_e             size,
    input  logic              is_signed,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  bytes  [NUM_LANES];
    logic [15:0] halves [NUM_HALVES];

    // Big-endian: offset 0 is the most significant byte.
    for (genvar o = 0; o < NUM_LANES; o++) begin : g_byte
        assign bytes[o] = rdata[DATA_W-1-8*o -: 8];
    end
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        assign halves[h] = rdata[DATA_W-1-16*h -: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    always_comb begin
        sel_b = bytes[off];
        sel_h = halves[off[OFF_W-1:1]];
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){is_signed & sel_b[7]}}, sel_b};
            SZ_HALF: result = {{(DATA_W-16){is_signed & sel_h[15]}}, sel_h};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(NUM_LANES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [OP_W-1:0]      req_op,
    input  logic                 req_alt,
    input  logic                 req_super,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [REG_W-1:0]     req_rd,
    input  logic [DATA_W-1:0]    req_sdata0,
    input  logic [DATA_W-1:0]    req_sdata1,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [NUM_LANES-1:0] mem_strb,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 wb_valid,
    output logic [REG_W-1:0]     wb_reg,
    output logic [DATA_W-1:0]    wb_data,
    output logic                 trap_valid,
    output logic [1:0]           trap_cause
);
    // ---------------- decode and trap check ----------------
    dec_t  dec_in;
    trap_e cause_in;

    lsu_decode #(.NUM_LANES(NUM_LANES)) u_decode (
        .op         (req_op),
        .alt        (req_alt),
        .super_mode (req_super),
        .addr_low   (req_addr[OFF_W:0]),
        .dec        (dec_in),
        .cause      (cause_in)
    );

    // ---------------- request state ----------------
    fsm_e              state_q;
    dec_t              dec_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  rd_q;
    logic [DATA_W-1:0] sd0_q, sd1_q;

    logic accept, beat_done, last_beat, second;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign second    = (state_q == ST_BEAT1);
    assign beat_done = mem_valid && mem_ready;
    assign last_beat = (dec_q.size != SZ_DBL) || second;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dec_q   <= '0;
            addr_q  <= '0;
            rd_q    <= '0;
            sd0_q   <= '0;
            sd1_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept && cause_in == TRAP_NONE) begin
                    state_q <= ST_BEAT0;
                    dec_q   <= dec_in;
                    addr_q  <= req_addr;
                    rd_q    <= req_rd;
                    sd0_q   <= req_sdata0;
                    sd1_q   <= req_sdata1;
                end
                ST_BEAT0: if (beat_done) state_q <= last_beat ? ST_IDLE : ST_BEAT1;
                ST_BEAT1: if (beat_done) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- memory beat ----------------
    logic [ADDR_W-1:0] word_base;
    size_e             lane_size;
    logic [DATA_W-1:0] src_word;

    assign word_base = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign lane_size = (dec_q.size == SZ_DBL) ? SZ_WORD : dec_q.size;
    assign src_word  = second ? sd1_q : sd0_q;

    assign mem_valid = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
    assign mem_we    = mem_valid && dec_q.is_store;
    assign mem_addr  = word_base + (second ? ADDR_W'(NUM_LANES) : '0);

    logic [NUM_LANES-1:0] strb_raw;
    lsu_store_lane #(.DATA_W(DATA_W)) u_store (
        .size  (lane_size),
        .off   (addr_q[OFF_W-1:0]),
        .src   (src_word),
        .strb  (strb_raw),
        .wdata (mem_wdata)
    );
    assign mem_strb = mem_we ? strb_raw : '0;

    // ---------------- load return ----------------
    logic [DATA_W-1:0] load_val;
    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .size      (lane_size),
        .is_signed (dec_q.is_signed),
        .off       (addr_q[OFF_W-1:0]),
        .rdata     (mem_rdata),
        .result    (load_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid   <= 1'b0;
            wb_reg     <= '0;
            wb_data    <= '0;
            trap_valid <= 1'b0;
            trap_cause <= TRAP_NONE;
        end else begin
            wb_valid   <= beat_done && !dec_q.is_store;
            if (beat_done && !dec_q.is_store) begin
                wb_reg  <= rd_q + REG_W'(second);
                wb_data <= load_val;
            end
            trap_valid <= accept && (cause_in != TRAP_NONE);
            if (accept) trap_cause <= cause_in;
        end
    end

    // ---------------- assertions ----------------
    assert_byte_onelane_R1: assert property (@(posedge clk) disable iff (rst)
        (mem_we && dec_q.size == SZ_BYTE) |-> ($countones(mem_strb) == 1));

    assert_word_addr_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

    assert_dbl_next_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_done && state_q == ST_BEAT0 && dec_q.size == SZ_DBL)
        |=> (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(NUM_LANES)));

    assert_hold_beat_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
            && $stable(mem_strb) && $stable(mem_wdata) && $stable(mem_we)));

    assert_illegal_first_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op > 4'd9) |=> (trap_valid && trap_cause == TRAP_ILLEGAL));

    assert_trap_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (!mem_valid && !wb_valid));

    assert_busy_R13: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !req_ready);
endmodule

// File: tb/tb_lsu_align_unit.sv
module tb_lsu_align_unit;
    localparam int K_WRITE = 0, K_READ = 1, K_WB = 2, K_TRAP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic        req_alt = 1'b0;
    logic        req_super = 1'b0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_rd = '0;
    logic [31:0] req_sdata0 = '0, req_sdata1 = '0;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_strb;
    logic        wb_valid, trap_valid;
    logic [4:0]  wb_reg;
    logic [31:0] wb_data;
    logic [1:0]  trap_cause;

    always #2 clk = ~clk;

    lsu_align_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_alt(req_alt), .req_super(req_super),
        .req_addr(req_addr), .req_rd(req_rd), .req_sdata0(req_sdata0),
        .req_sdata1(req_sdata1), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_strb(mem_strb),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wb_valid(wb_valid),
        .wb_reg(wb_reg), .wb_data(wb_data), .trap_valid(trap_valid),
        .trap_cause(trap_cause)
    );

    // ---------------- memory model ----------------
    logic [31:0] bmem [16];
    logic [7:0]  cyc = '0;
    assign mem_rdata = bmem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (!rst && mem_valid && mem_ready && mem_we) begin
            for (int j = 0; j < 4; j++)
                if (mem_strb[j]) bmem[mem_addr[5:2]][8*j +: 8] <= mem_wdata[8*j +: 8];
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 8'd1;
        #1;
        mem_ready = !rst && mem_valid && (cyc[1:0] != 2'd0);
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int          kind;
        logic [31:0] addr;
        logic [3:0]  strb;
        logic [31:0] data;
        logic [4:0]  rg;
        string       req;
    } exp_t;

    exp_t q[$];
    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic observe(input int kind, input logic [31:0] addr, input logic [3:0] strb,
                           input logic [31:0] data, input logic [4:0] rg);
        exp_t e;
        if (q.size() == 0) begin
            chk(1'b0, "R12 unexpected event", {32'(kind), addr}, 64'hFFFF_FFFF_FFFF_FFFF);
            return;
        end
        e = q.pop_front();
        if (e.kind != kind) begin
            chk(1'b0, {e.req, " event kind"}, 64'(kind), 64'(e.kind));
            return;
        end
        case (kind)
            K_WRITE: chk(addr == e.addr && strb == e.strb && data == e.data, e.req,
                         {addr[15:0], 12'h0, strb, data}, {e.addr[15:0], 12'h0, e.strb, e.data});
            K_READ:  chk(addr == e.addr, e.req, 64'(addr), 64'(e.addr));
            K_WB:    chk(rg == e.rg && data == e.data, e.req, {27'h0, rg, data}, {27'h0, e.rg, e.data});
            default: chk(data[1:0] == e.data[1:0], e.req, 64'(data[1:0]), 64'(e.data[1:0]));
        endcase
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wb_valid)   observe(K_WB, '0, '0, wb_data, wb_reg);
            if (trap_valid) observe(K_TRAP, '0, '0, {30'h0, trap_cause}, '0);
            if (mem_valid && mem_ready)
                observe(mem_we ? K_WRITE : K_READ, mem_addr, mem_strb, mem_wdata, '0);
        end
    end

    // ---------------- reference model ----------------
    function automatic logic [1:0] ref_trap(input int op, input bit alt, input bit sup, input logic [31:0] a);
        if (op > 9) return 2'd1;
        if (alt && !sup) return 2'd2;
        if ((op == 1 || op == 5 || op == 7) && a[0]) return 2'd3;
        if ((op == 2 || op == 8) && a[1:0] != 2'd0) return 2'd3;
        if ((op == 3 || op == 9) && a[2:0] != 3'd0) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [31:0] ref_load(input int op, input logic [31:0] w, input logic [1:0] off);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[31 - 8*off -: 8];
        h = off[1] ? w[15:0] : w[31:16];
        case (op)
            0: return {24'h0, b};
            4: return {{24{b[7]}}, b};
            1: return {16'h0, h};
            5: return {{16{h[15]}}, h};
            default: return w;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1: return "R5";
            4, 5: return "R4";
            2:    return "R5";
            3, 9: return "R6";
            6:    return "R1";
            7:    return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic push(input int kind, input logic [31:0] addr, input logic [3:0] strb,
                        input logic [31:0] data, input logic [4:0] rg, input string req);
        exp_t e;
        e.kind = kind; e.addr = addr; e.strb = strb; e.data = data; e.rg = rg; e.req = req;
        q.push_back(e);
    endtask

    task automatic send(input int op, input bit alt, input bit sup, input logic [31:0] a,
                        input logic [4:0] rd, input logic [31:0] d0, input logic [31:0] d1,
                        input string trap_req);
        logic [1:0]  tc;
        logic [31:0] wa;
        string       t;
        while (!req_ready) @(negedge clk);
        tc = ref_trap(op, alt, sup, a);
        wa = {a[31:2], 2'b00};
        t  = tag_of(op);
        if (tc != 2'd0) push(K_TRAP, '0, '0, {30'h0, tc}, '0, trap_req);
        else begin
            case (op)
                0, 1, 2, 4, 5: begin
                    push(K_READ, wa, '0, '0, '0, t);
                    push(K_WB, '0, '0, ref_load(op, bmem[wa[5:2]], a[1:0]), rd, t);
                end
                3: begin
                    push(K_READ, wa, '0, '0, '0, "R6");
                    push(K_WB, '0, '0, bmem[wa[5:2]], rd, "R6");
                    push(K_READ, wa + 32'd4, '0, '0, '0, "R6");
                    push(K_WB, '0, '0, bmem[wa[5:2] + 4'd1], rd + 5'd1, "R6");
                end
                6: push(K_WRITE, wa, 4'b1000 >> a[1:0], {4{d0[7:0]}}, '0, "R1");
                7: push(K_WRITE, wa, a[1] ? 4'b0011 : 4'b1100, {2{d0[15:0]}}, '0, "R2");
                8: push(K_WRITE, wa, 4'hF, d0, '0, "R3");
                default: begin
                    push(K_WRITE, wa, 4'hF, d0, '0, "R6");
                    push(K_WRITE, wa + 32'd4, 4'hF, d1, '0, "R6");
                end
            endcase
        end
        req_op = 4'(op); req_alt = alt; req_super = sup; req_addr = a; req_rd = rd;
        req_sdata0 = d0; req_sdata1 = d1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 16; i++)
            bmem[i] = {8'h80 | 8'(i), 8'h7E, 8'hF0 ^ 8'(i), 8'h11 + 8'(i)};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !mem_valid && !wb_valid && !trap_valid, "R13 reset state",
            {60'h0, req_ready, mem_valid, wb_valid, trap_valid}, 64'h8);

        // Loads, each lane (R4, R5)
        for (int o = 0; o < 4; o++) send(0, 0, 0, 32'h0000_0010 + 32'(o), 5'd1, '0, '0, "");
        for (int o = 0; o < 4; o++) send(4, 0, 0, 32'h0000_0014 + 32'(o), 5'd2, '0, '0, "");
        send(1, 0, 0, 32'h18, 5'd3, '0, '0, "");
        send(1, 0, 0, 32'h1A, 5'd3, '0, '0, "");
        send(5, 0, 0, 32'h18, 5'd4, '0, '0, "");
        send(5, 0, 0, 32'h1A, 5'd4, '0, '0, "");
        send(2, 0, 0, 32'h1C, 5'd5, '0, '0, "");
        // Stores at each lane (R1, R2, R3)
        for (int o = 0; o < 4; o++) send(6, 0, 0, 32'h20 + 32'(o), '0, 32'h1234_56A0 + 32'(o), '0, "");
        send(7, 0, 0, 32'h24, '0, 32'hDEAD_8001, '0, "");
        send(7, 0, 0, 32'h26, '0, 32'hBEEF_7FFE, '0, "");
        send(8, 0, 0, 32'h28, '0, 32'hCAFE_F00D, '0, "");
        // Read back stored bytes through signed/unsigned loads
        send(4, 0, 0, 32'h20, 5'd7, '0, '0, "");
        send(1, 0, 0, 32'h26, 5'd7, '0, '0, "");
        // Double word (R6, R7 under wait states)
        send(9, 0, 0, 32'h30, '0, 32'h0102_0304, 32'hF5F6_F7F8, "");
        send(3, 0, 0, 32'h30, 5'd10, '0, '0, "");
        send(3, 1, 1, 32'h08, 5'd20, '0, '0, "");
        // Misalignment (R8); byte never misaligned
        send(1, 0, 0, 32'h41, 5'd1, '0, '0, "R8 half odd");
        send(8, 0, 0, 32'h02, '0, 32'hFFFF_FFFF, '0, "R8 word off2");
        send(2, 0, 0, 32'h00, 5'd6, '0, '0, "");
        send(3, 0, 0, 32'h04, 5'd1, '0, '0, "R8 double off4");
        send(9, 0, 0, 32'h0C, '0, '0, '0, "R8 double store");
        send(6, 0, 0, 32'h03, '0, 32'h55, '0, "");
        // Privilege (R9)
        send(2, 1, 0, 32'h00, 5'd1, '0, '0, "R9 alt user");
        send(2, 1, 1, 32'h00, 5'd1, '0, '0, "");
        // Illegal (R10) and priority (R11)
        send(12, 0, 1, 32'h00, '0, '0, '0, "R10 code 12");
        send(15, 1, 0, 32'h03, '0, '0, '0, "R11 illegal over all");
        send(8, 1, 0, 32'h01, '0, '0, '0, "R11 priv over align");
        // After trapped stores memory is intact (R12)
        send(2, 0, 0, 32'h00, 5'd9, '0, '0, "");
        send(2, 0, 0, 32'h0C, 5'd9, '0, '0, "");

        repeat (20) @(negedge clk);
        chk(q.size() == 0, "R13 all expected events seen", 64'(q.size()), 64'h0);
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule